// File: doc/BRIEF.md
# AES Round-Key Schedule Generator

This block turns an AES user key into the complete set of round keys that a cipher datapath needs. The key length, 128, 192 or 256 bits, is a compile-time parameter. When the key-valid input rises, the block captures the key. It then computes one 32-bit schedule column per clock cycle and writes each column into four column-wide memories that can map onto block RAM. When the last column has been written, it raises `key_ready`.

The schedule is kept for as long as key-valid stays high, so any number of data blocks can use it without a new expansion. A cipher datapath reads a 128-bit round key by presenting a round index, and the key appears one cycle later. A reverse-order flag maps index k to round Nr-k. With this flag a decryption datapath can walk the same storage from the last round key to the first. Dropping key-valid for at least one cycle discards the schedule, and the next rising edge of key-valid starts a complete new expansion.

Top module: `aes_key_expander`

## Requirements
- R1: After synchronous reset `key_ready` is 0, and it stays 0 while `key_valid` is low.
- R2: `key_ready` becomes 1 exactly 4*Nr+1 clock edges after the first edge that samples `key_valid` high while idle. This is one capture cycle followed by one column per cycle for 40, 48 or 56 cycles.
- R3: Schedule column i for i >= Nk is w[i-Nk] XOR t. Here t is SubWord(RotWord(w[i-1])) XOR Rcon when i mod Nk = 0. When Nk = 8 and i mod 8 = 4, t is SubWord(w[i-1]). In every other case t is w[i-1]. Rcon starts at 0x01 in the top byte and is doubled in GF(2^8) for each later use.
- R4: Word k of the user key sits at `user_key[KEY_BITS-1-32k -: 32]` and becomes column k, so word 0 is in the most significant bits.
- R5: Round key r is {w[4r], w[4r+1], w[4r+2], w[4r+3]}, with w[4r] in bits 127:96. It appears on `round_key` one cycle after `rk_index` is presented.
- R6: With `rk_reverse` = 0 the block returns round `rk_index`. With `rk_reverse` = 1 it returns round Nr-`rk_index`. `rk_index` must lie in 0..Nr.
- R7: While `key_valid` stays high after expansion, `key_ready` stays 1 and the stored keys do not change. Any change on `user_key` during that time has no effect.
- R8: A clock edge that samples `key_valid` low clears `key_ready` at that edge, which also aborts an expansion in progress. The next high level restarts expansion from the captured key.
- R9: `KEY_BITS` of 128, 192 or 256 gives Nr of 10, 12 or 14 rounds. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | High while the key is to be used; a rising level starts expansion |
| user_key | input | KEY_BITS | User key, word 0 in the most significant bits |
| rk_index | input | IDX_W | Round index, 0..Nr |
| rk_reverse | input | 1 | 1 selects round Nr-`rk_index` (decrypt order) |
| key_ready | output | 1 | All round keys stored |
| round_key | output | 128 | Selected round key, one cycle after the index |

## Verification
The assertions check on every cycle how `key_ready` responds to `key_valid`: it must drop after a low sample, it must rise only after a high sample, and it must stay high while the key is held. A counter in the checker confirms the 4*Nr+1 cycle expansion length, and another assertion requires a stable read index to give a stable round key. The column values can only be shown by the bench. It compares every round key, in forward and reverse order and for all three key lengths, against a schedule that it computes itself and against the published last round keys. The bench scenarios also cover an ignored key change, a one-cycle drop of key-valid and an abort in the middle of an expansion.

// File: rtl/kx_pkg.sv
package kx_pkg;

  typedef enum logic [1:0] {
    KX_IDLE   = 2'd0,
    KX_EXPAND = 2'd1,
    KX_READY  = 2'd2
  } kx_state_e;

  typedef logic [7:0] sbox_rom_t [256];

  // multiply by x in GF(2^8) with the AES polynomial
  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = 8'h00;
    x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // inverse as a^254 followed by the affine map
  function automatic logic [7:0] sbox_calc(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] inv;
    sq  = a;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction

  function automatic sbox_rom_t build_sbox_rom();
    sbox_rom_t t;
    for (int k = 0; k < 256; k++) t[k] = sbox_calc(8'(k));
    return t;
  endfunction

endpackage

// File: rtl/kx_sbox.sv
module kx_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  import kx_pkg::*;

  localparam sbox_rom_t ROM = build_sbox_rom();

  assign dout = ROM[din];

endmodule

// File: rtl/kx_word_gen.sv
module kx_word_gen #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] prev,
  input  logic [WORD_W-1:0] oldest,
  input  logic [7:0]        rcon,
  input  logic              do_rot,
  input  logic              do_sub,
  output logic [WORD_W-1:0] word
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] rotated;
  logic [WORD_W-1:0] subbed;
  logic [WORD_W-1:0] mixed;

  assign rotated = do_rot ? {prev[WORD_W-9:0], prev[WORD_W-1 -: 8]} : prev;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    kx_sbox u_sbox (
      .din  (rotated[8*b +: 8]),
      .dout (subbed[8*b +: 8])
    );
  end

  always_comb begin
    if (do_rot)      mixed = subbed ^ {rcon, {(WORD_W-8){1'b0}}};
    else if (do_sub) mixed = subbed;
    else             mixed = prev;
  end

  assign word = oldest ^ mixed;

endmodule

// File: rtl/kx_col_bank.sv
module kx_col_bank #(
  parameter int DEPTH  = 14,
  parameter int WORD_W = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wen,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/aes_key_expander.sv
module aes_key_expander #(
  parameter int KEY_BITS = 256,
  localparam int NK      = KEY_BITS / 32,
  localparam int NR      = NK + 6,
  localparam int IDX_W   = $clog2(NR + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                key_valid,
  input  logic [KEY_BITS-1:0] user_key,
  input  logic [IDX_W-1:0]    rk_index,
  input  logic                rk_reverse,
  output logic                key_ready,
  output logic [127:0]        round_key
);
  import kx_pkg::*;

  localparam int LAST_J   = 4 * (NR + 1) - 1;
  localparam int J_W      = $clog2(LAST_J + 1);
  localparam int PH_W     = $clog2(NK);
  localparam int START_PH = 4 % NK;
  localparam int AW       = $clog2(NR);
  localparam int NCOLS    = 4;

  if (KEY_BITS != 128 && KEY_BITS != 192 && KEY_BITS != 256) begin : g_bad_key
    $error("aes_key_expander: KEY_BITS must be 128, 192 or 256");
  end

  kx_state_e        state_q;
  logic             ready_q;
  logic [31:0]      win_q [NK];
  logic [J_W-1:0]   j_q;
  logic [PH_W-1:0]  phase_q;
  logic [7:0]       rcon_q;
  logic [1:0]       col_q;
  logic [AW-1:0]    row_q;
  logic [127:0]     rk0_q;
  logic             sel0_q;

  logic [31:0]      key_word [NK];
  logic [31:0]      copy_word;
  logic [31:0]      gen_word;
  logic [31:0]      wr_word;
  logic             is_copy;
  logic             do_rot;
  logic             do_sub;
  logic             wr_en;
  logic [IDX_W-1:0] eff_idx;
  logic [AW-1:0]    rd_addr;
  logic [31:0]      bank_q [NCOLS];

  for (genvar k = 0; k < NK; k++) begin : g_key_word
    assign key_word[k] = user_key[KEY_BITS-1-32*k -: 32];
  end

  always_comb begin
    copy_word = '0;
    for (int k = 0; k < NK; k++) begin
      if (j_q == J_W'(k)) copy_word = key_word[k];
    end
  end

  assign is_copy = (j_q < J_W'(NK));
  assign do_rot  = (phase_q == '0);

  if (NK == 8) begin : g_sub_only
    assign do_sub = (phase_q == PH_W'(4));
  end else begin : g_no_sub_only
    assign do_sub = 1'b0;
  end

  kx_word_gen #(.WORD_W(32)) u_word_gen (
    .prev   (win_q[NK-1]),
    .oldest (win_q[0]),
    .rcon   (rcon_q),
    .do_rot (do_rot),
    .do_sub (do_sub),
    .word   (gen_word)
  );

  assign wr_word = is_copy ? copy_word : gen_word;
  assign wr_en   = (state_q == KX_EXPAND) && key_valid;

  // sequencing: capture, then one column per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KX_IDLE;
      ready_q <= 1'b0;
      j_q     <= '0;
      phase_q <= '0;
      rcon_q  <= 8'h01;
      col_q   <= '0;
      row_q   <= '0;
    end else if (!key_valid) begin
      state_q <= KX_IDLE;
      ready_q <= 1'b0;
    end else begin
      case (state_q)
        KX_IDLE: begin
          for (int k = 0; k < NK; k++) win_q[k] <= key_word[k];
          rk0_q   <= user_key[KEY_BITS-1 -: 128];
          j_q     <= J_W'(4);
          phase_q <= PH_W'(START_PH);
          rcon_q  <= 8'h01;
          col_q   <= '0;
          row_q   <= '0;
          state_q <= KX_EXPAND;
        end
        KX_EXPAND: begin
          if (!is_copy) begin
            for (int k = 0; k < NK - 1; k++) win_q[k] <= win_q[k+1];
            win_q[NK-1] <= gen_word;
            if (do_rot) rcon_q <= xtime(rcon_q);
          end
          phase_q <= (phase_q == PH_W'(NK - 1)) ? '0 : phase_q + 1'b1;
          col_q   <= col_q + 2'd1;
          if (col_q == 2'd3) row_q <= row_q + 1'b1;
          j_q     <= j_q + 1'b1;
          if (j_q == J_W'(LAST_J)) begin
            state_q <= KX_READY;
            ready_q <= 1'b1;
          end
        end
        default: begin
          state_q <= KX_READY;
        end
      endcase
    end
  end

  // read side: shared store, reversed index for decryption
  assign eff_idx = rk_reverse ? (IDX_W'(NR) - rk_index) : rk_index;
  assign rd_addr = (eff_idx == '0) ? '0 : AW'(eff_idx - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) sel0_q <= 1'b1;
    else     sel0_q <= (eff_idx == '0);
  end

  for (genvar c = 0; c < NCOLS; c++) begin : g_bank
    kx_col_bank #(.DEPTH(NR), .WORD_W(32)) u_bank (
      .clk   (clk),
      .wen   (wr_en && (col_q == 2'(c))),
      .waddr (row_q),
      .wdata (wr_word),
      .raddr (rd_addr),
      .rdata (bank_q[c])
    );
  end

  assign key_ready = ready_q;
  assign round_key = sel0_q ? rk0_q : {bank_q[0], bank_q[1], bank_q[2], bank_q[3]};

endmodule

// File: rtl/kx_checker.sv
module kx_checker #(
  parameter int KEY_BITS = 256,
  localparam int NK      = KEY_BITS / 32,
  localparam int NR      = NK + 6,
  localparam int IDX_W   = $clog2(NR + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             key_valid,
  input logic             key_ready,
  input logic [IDX_W-1:0] rk_index,
  input logic             rk_reverse,
  input logic [127:0]     round_key
);
  localparam int EXP_CYC = 4 * NR + 1;

  logic [7:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !key_valid) run_cnt <= '0;
    else if (!key_ready)   run_cnt <= run_cnt + 8'd1;
  end

  assert_drop_on_invalid_R8: assert property (@(posedge clk) disable iff (rst)
    !key_valid |=> !key_ready);

  assert_ready_needs_valid_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(key_ready) |-> $past(key_valid));

  assert_ready_held_R7: assert property (@(posedge clk) disable iff (rst)
    (key_ready && key_valid) |=> key_ready);

  assert_expand_length_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(key_ready) |-> (run_cnt == 8'(EXP_CYC)));

  assert_stable_key_R5: assert property (@(posedge clk) disable iff (rst)
    (key_ready && $past(key_ready) && $stable(rk_index) && $stable(rk_reverse))
      |=> $stable(round_key));

endmodule

bind aes_key_expander kx_checker #(.KEY_BITS(KEY_BITS)) u_kx_checker (
  .clk        (clk),
  .rst        (rst),
  .key_valid  (key_valid),
  .key_ready  (key_ready),
  .rk_index   (rk_index),
  .rk_reverse (rk_reverse),
  .round_key  (round_key)
);

// File: tb/test_aes_key_expander.sv
module test_aes_key_expander;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   n_checks = 0;
  int   n_errors = 0;

  always #10 clk = ~clk;

  localparam logic [255:0] KAT_KEY [3] = '{
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0},
    {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0},
    256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4
  };
  localparam logic [127:0] KAT_LAST [3] = '{
    128'hd014f9a8c9ee2589e13f0cc8b6630ca6,
    128'he98ba06f448c773c8ecc720401002202,
    128'hfe4890d1e6188d0b046df344706c631e
  };

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference arithmetic, written independently of the design
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] aa = a;
    logic [7:0] bb = b;
    while (bb != 0) begin
      if (bb[0]) r ^= aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
      bb = bb >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] a);
    logic [7:0] inv = 0;
    logic [7:0] s;
    for (int b = 1; b < 256; b++) if (m_mul(a, 8'(b)) == 8'h01) inv = 8'(b);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8]
             ^ ((8'h63 >> i) & 8'h01) != 0;
    return s;
  endfunction

  function automatic logic [31:0] m_subw(input logic [31:0] w);
    return {m_sbox(w[31:24]), m_sbox(w[23:16]), m_sbox(w[15:8]), m_sbox(w[7:0])};
  endfunction

  for (genvar g = 0; g < 3; g++) begin : g_sz
    localparam int KB = 128 + 64 * g;
    localparam int NK = KB / 32;
    localparam int NR = NK + 6;

    logic          key_valid = 1'b0;
    logic [KB-1:0] user_key  = '0;
    logic [3:0]    rk_index  = '0;
    logic          rk_reverse = 1'b0;
    logic          key_ready;
    logic [127:0]  round_key;
    logic [31:0]   w_exp [60];
    bit            done_g = 1'b0;

    aes_key_expander #(.KEY_BITS(KB)) i_aes_key_expander (
      .clk        (clk),
      .rst        (rst),
      .key_valid  (key_valid),
      .user_key   (user_key),
      .rk_index   (rk_index),
      .rk_reverse (rk_reverse),
      .key_ready  (key_ready),
      .round_key  (round_key)
    );

    task automatic model(input logic [KB-1:0] k);
      for (int i = 0; i < 4 * (NR + 1); i++) begin
        logic [31:0] t;
        if (i < NK) begin
          w_exp[i] = k[KB-1-32*i -: 32];
        end else begin
          t = w_exp[i-1];
          if (i % NK == 0) begin
            logic [7:0] rc = 8'h01;
            for (int n = 1; n < i / NK; n++) rc = m_mul(rc, 8'h02);
            t = m_subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
          end else if (NK > 6 && i % NK == 4) begin
            t = m_subw(t);
          end
          w_exp[i] = w_exp[i-NK] ^ t;
        end
      end
    endtask

    function automatic logic [127:0] exp_rk(input int r);
      return {w_exp[4*r], w_exp[4*r+1], w_exp[4*r+2], w_exp[4*r+3]};
    endfunction

    task automatic read_rk(input int idx, input bit rev, output logic [127:0] v);
      @(negedge clk);
      rk_index   = 4'(idx);
      rk_reverse = rev;
      @(negedge clk);
      v = round_key;
    endtask

    task automatic compare_all(input string tag);
      logic [127:0] v;
      for (int r = 0; r <= NR; r++) begin
        read_rk(r, 1'b0, v);
        chk(v == exp_rk(r), $sformatf("R3 R4 R5 %s k%0d fwd round %0d", tag, KB, r), v, exp_rk(r));
      end
      for (int r = 0; r <= NR; r++) begin
        read_rk(r, 1'b1, v);
        chk(v == exp_rk(NR - r), $sformatf("R6 %s k%0d rev index %0d", tag, KB, r), v, exp_rk(NR - r));
      end
    endtask

    task automatic start_count(output int n);
      @(negedge clk);
      key_valid = 1'b1;
      n = 0;
      for (int c = 0; c < 300; c++) begin
        @(negedge clk);
        n++;
        if (key_ready) break;
      end
    endtask

    initial begin
      logic [127:0] v;
      logic [KB-1:0] key2;
      int n;
      while (rst) @(negedge clk);
      chk(key_ready == 1'b0, $sformatf("R1 k%0d ready after reset", KB), 128'(key_ready), 128'h0);
      repeat (3) @(negedge clk);
      chk(key_ready == 1'b0, $sformatf("R1 k%0d ready with valid low", KB), 128'(key_ready), 128'h0);

      // known-answer key
      user_key = KAT_KEY[g][255 -: KB];
      model(user_key);
      start_count(n);
      chk(n == 4 * NR + 1, $sformatf("R2 R9 k%0d expansion cycles", KB), 128'(n), 128'(4 * NR + 1));
      compare_all("kat");
      read_rk(NR, 1'b0, v);
      chk(v == KAT_LAST[g], $sformatf("R3 k%0d published last round key", KB), v, KAT_LAST[g]);

      // key input changes while valid is held are ignored
      user_key = ~user_key;
      repeat (20) @(negedge clk);
      chk(key_ready == 1'b1, $sformatf("R7 k%0d ready held", KB), 128'(key_ready), 128'h1);
      read_rk(0, 1'b0, v);
      chk(v == exp_rk(0), $sformatf("R7 k%0d round 0 retained", KB), v, exp_rk(0));
      read_rk(NR, 1'b0, v);
      chk(v == exp_rk(NR), $sformatf("R7 k%0d last round retained", KB), v, exp_rk(NR));

      // one-cycle drop, then a new key
      key2 = KAT_KEY[g][255 -: KB] ^ {(KB/32){32'h0f1e2d3c}};
      @(negedge clk);
      key_valid = 1'b0;
      user_key  = key2;
      @(negedge clk);
      chk(key_ready == 1'b0, $sformatf("R8 k%0d ready drops", KB), 128'(key_ready), 128'h0);
      model(key2);
      start_count(n);
      chk(n == 4 * NR + 1, $sformatf("R2 R8 k%0d restart cycles", KB), 128'(n), 128'(4 * NR + 1));
      compare_all("key2");

      // abort in the middle of an expansion
      @(negedge clk);
      key_valid = 1'b0;
      user_key  = KAT_KEY[g][255 -: KB];
      @(negedge clk);
      key_valid = 1'b1;
      repeat (10) @(negedge clk);
      key_valid = 1'b0;
      @(negedge clk);
      chk(key_ready == 1'b0, $sformatf("R8 k%0d abort ready low", KB), 128'(key_ready), 128'h0);
      model(user_key);
      start_count(n);
      chk(n == 4 * NR + 1, $sformatf("R8 k%0d full restart after abort", KB), 128'(n), 128'(4 * NR + 1));
      compare_all("abort");
      done_g = 1'b1;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
  end

  initial begin
    fork
      wait (g_sz[0].done_g && g_sz[1].done_g && g_sz[2].done_g);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule